// File: doc/BRIEF.md
# Event Counter Bank with Overflow

This block holds a set of event counters. A parameterised number are general-purpose counters, each steered by its own select register. The rest are fixed-function counters, all steered by one shared control word that packs a 4-bit field per counter. A counter advances by one on each clock in which its event input is high and three conditions hold: its local enable is on, the current privilege mode is one it accepts, and its bit in a global enable mask is set.

When a counter wraps to zero, a sticky bit in a global status register is set. Software clears status bits by writing a mask to a clear register. The interrupt output stays high while any set status bit belongs to a counter whose interrupt enable is on.

All state is reached through a flat register port. A write takes effect on the clock edge at which the write strobe is high. Read data is registered: it shows the register selected by the address one cycle later.

Top module: `evt_counter_bank`

## Requirements
- R1: After reset every counter, select register, the fixed control word, the global mask and the status register read zero, and `irq_o` is low.
- R2: A general-purpose counter i (select register at address 0x20+i; bit 0 = count in privileged mode, bit 1 = count in user mode, bit 2 = local enable, bit 3 = interrupt enable) increments once per cycle in which `evt_in[i]` is high, bit 2 is set, the bit for the current mode is set (`priv_mode`=1 is privileged), and global mask bit i is set. Otherwise it holds.
- R3: Fixed counter j uses field bits [4j+3:4j] of the control word at address 0x03 (bit 0 privileged, bit 1 user, bit 3 interrupt enable, bit 2 unused). It counts `evt_in[G+j]` when the mode bit matches and global mask bit 32+j is set. A zero field stops it.
- R4: With the global mask (address 0x00) at zero, no counter changes except by a register write.
- R5: Counters wrap modulo 2^CNT_W. The wrap sets status bit i for general-purpose counter i, or bit 32+j for fixed counter j, on the same edge. A counter preset to 1-N reads 1 after N events, with its status bit set.
- R6: Writing a mask to address 0x02 clears exactly the status bits (read at 0x01) that are 1 in the mask. A wrap on the same edge keeps its bit set.
- R7: `irq_o` rises one cycle after a status bit whose counter has its interrupt enable set becomes 1. It stays low for wraps of counters without that enable, and falls one cycle after the last such bit is cleared.
- R8: A counter written while counting (GP at 0x10+i, fixed at 0x30+j) continues from the written value. A write takes priority over an event in the same cycle.
- R9: Global mask writes keep only implemented bit positions. Unmapped addresses read zero. Counter reads are zero-extended to 64 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| priv_mode | input | 1 | 1 = privileged mode, 0 = user mode |
| evt_in | input | NUM_GP+NUM_FIX | Event pulse per counter, GP counters first |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 64 | Write data |
| bus_rdata | output | 64 | Registered read data for the previous cycle's address |
| irq_o | output | 1 | Overflow interrupt level |

## Verification
The assertions assume `evt_in` and `priv_mode` are synchronous to `clk` and steady around each edge. They also assume a register write and a status clear never name a bit that a wrap sets on the same edge, unless that overlap is the case under test. The bench drives all inputs on the falling edge and holds event inputs low while it reconfigures controls, except in the running-write scenario. It keeps clear masks away from counters that are counting at that moment.

// File: rtl/evb_pkg.sv
package evb_pkg;
  localparam int DATA_W   = 64;
  localparam int ADDR_W   = 8;
  localparam int FIX_BASE = 32;

  localparam logic [ADDR_W-1:0] A_GLOBAL = 8'h00;
  localparam logic [ADDR_W-1:0] A_STATUS = 8'h01;
  localparam logic [ADDR_W-1:0] A_CLEAR  = 8'h02;
  localparam logic [ADDR_W-1:0] A_FIXCTL = 8'h03;
  localparam logic [ADDR_W-1:0] A_GPCNT  = 8'h10;
  localparam logic [ADDR_W-1:0] A_GPSEL  = 8'h20;
  localparam logic [ADDR_W-1:0] A_FXCNT  = 8'h30;

  typedef struct packed {
    logic irq_en;
    logic local_en;
    logic cnt_user;
    logic cnt_priv;
  } gp_sel_t;

  function automatic logic mode_ok(logic priv, logic user_bit, logic priv_bit);
    return priv ? priv_bit : user_bit;
  endfunction
endpackage

// File: rtl/evb_counter.sv
module evb_counter #(
  parameter int CNT_W = 48
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc,
  input  logic             ld,
  input  logic [CNT_W-1:0] ld_val,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o
);
  assign wrap_o = inc & ~ld & (&cnt_o);

  always_ff @(posedge clk) begin
    if (rst)      cnt_o <= '0;
    else if (ld)  cnt_o <= ld_val;
    else if (inc) cnt_o <= cnt_o + 1'b1;
  end

  // R2: an accepted event advances the value by one
  a_r2_step: assert property (@(posedge clk) disable iff (rst)
    (inc && !ld) |=> (cnt_o == $past(cnt_o) + 1'b1));
  // R8: a write lands even with an event in the same cycle
  a_r8_load: assert property (@(posedge clk) disable iff (rst)
    ld |=> (cnt_o == $past(ld_val)));
  // R5: a wrap leaves the counter at zero
  a_r5_wrap_zero: assert property (@(posedge clk) disable iff (rst)
    wrap_o |=> (cnt_o == '0));
endmodule

// File: rtl/evb_status.sv
module evb_status #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] wrap_vec,
  input  logic         clr_en,
  input  logic [W-1:0] clr_mask,
  input  logic [W-1:0] ie_vec,
  output logic [W-1:0] status_o,
  output logic         irq_o
);
  logic [W-1:0] clr_eff;
  assign clr_eff = clr_en ? clr_mask : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      status_o <= '0;
      irq_o    <= 1'b0;
    end else begin
      status_o <= (status_o & ~clr_eff) | wrap_vec;
      irq_o    <= |(status_o & ie_vec);
    end
  end

  // R5: every wrap lands in status
  a_r5_wrap_sets: assert property (@(posedge clk) disable iff (rst)
    (|wrap_vec) |=> ((status_o & $past(wrap_vec)) == $past(wrap_vec)));
  // R6: cleared bits drop when no wrap collides
  a_r6_clear_exact: assert property (@(posedge clk) disable iff (rst)
    (clr_en && ((clr_mask & wrap_vec) == '0)) |=> ((status_o & $past(clr_mask)) == '0));
  // R6: without a clear, status is sticky
  a_r6_sticky: assert property (@(posedge clk) disable iff (rst)
    !clr_en |=> ((status_o & $past(status_o)) == $past(status_o)));
  // R7: the interrupt needs an enabled pending bit one cycle earlier
  a_r7_irq_cause: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> $past(|(status_o & ie_vec)));
endmodule

// File: rtl/evt_counter_bank.sv
module evt_counter_bank
  import evb_pkg::*;
#(
  parameter int NUM_GP  = 4,
  parameter int NUM_FIX = 3,
  parameter int CNT_W   = 48
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      priv_mode,
  input  logic [NUM_GP+NUM_FIX-1:0] evt_in,
  input  logic                      bus_wr,
  input  logic [7:0]                bus_addr,
  input  logic [63:0]               bus_wdata,
  output logic [63:0]               bus_rdata,
  output logic                      irq_o
);
  localparam int NUM_ALL = NUM_GP + NUM_FIX;
  localparam int FC_W    = 4 * NUM_FIX;

  function automatic logic [DATA_W-1:0] impl_mask();
    logic [DATA_W-1:0] m;
    m = '0;
    for (int i = 0; i < NUM_GP; i++)  m[i] = 1'b1;
    for (int j = 0; j < NUM_FIX; j++) m[FIX_BASE+j] = 1'b1;
    return m;
  endfunction
  localparam logic [DATA_W-1:0] IMPL = impl_mask();

  gp_sel_t                      sel_q [NUM_GP];
  logic [FC_W-1:0]              fix_ctl_q;
  logic [DATA_W-1:0]            gmask_q;
  logic [NUM_ALL-1:0][CNT_W-1:0] cnt;
  logic [NUM_ALL-1:0]           inc, cwr, wrap;
  logic [DATA_W-1:0]            wrap_vec, ie_vec, status;
  logic [DATA_W-1:0]            rd_mux;

  // Per-counter enable, load and wrap routing
  always_comb begin
    inc      = '0;
    cwr      = '0;
    wrap_vec = '0;
    ie_vec   = '0;
    for (int i = 0; i < NUM_GP; i++) begin
      inc[i] = evt_in[i] & sel_q[i].local_en & gmask_q[i]
             & mode_ok(priv_mode, sel_q[i].cnt_user, sel_q[i].cnt_priv);
      cwr[i] = bus_wr && (bus_addr == ADDR_W'(A_GPCNT + i));
      wrap_vec[i] = wrap[i];
      ie_vec[i]   = sel_q[i].irq_en;
    end
    for (int j = 0; j < NUM_FIX; j++) begin
      inc[NUM_GP+j] = evt_in[NUM_GP+j] & gmask_q[FIX_BASE+j]
                    & mode_ok(priv_mode, fix_ctl_q[4*j+1], fix_ctl_q[4*j]);
      cwr[NUM_GP+j] = bus_wr && (bus_addr == ADDR_W'(A_FXCNT + j));
      wrap_vec[FIX_BASE+j] = wrap[NUM_GP+j];
      ie_vec[FIX_BASE+j]   = fix_ctl_q[4*j+3];
    end
  end

  generate
    for (genvar k = 0; k < NUM_ALL; k++) begin : g_cnt
      evb_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk    (clk),
        .rst    (rst),
        .inc    (inc[k]),
        .ld     (cwr[k]),
        .ld_val (bus_wdata[CNT_W-1:0]),
        .cnt_o  (cnt[k]),
        .wrap_o (wrap[k])
      );
    end
  endgenerate

  evb_status #(.W(DATA_W)) u_status (
    .clk      (clk),
    .rst      (rst),
    .wrap_vec (wrap_vec),
    .clr_en   (bus_wr && (bus_addr == A_CLEAR)),
    .clr_mask (bus_wdata),
    .ie_vec   (ie_vec),
    .status_o (status),
    .irq_o    (irq_o)
  );

  // Control registers
  always_ff @(posedge clk) begin
    if (rst) begin
      gmask_q   <= '0;
      fix_ctl_q <= '0;
      for (int i = 0; i < NUM_GP; i++) sel_q[i] <= '0;
    end else if (bus_wr) begin
      if (bus_addr == A_GLOBAL) gmask_q   <= bus_wdata & IMPL;
      if (bus_addr == A_FIXCTL) fix_ctl_q <= bus_wdata[FC_W-1:0];
      for (int i = 0; i < NUM_GP; i++)
        if (bus_addr == ADDR_W'(A_GPSEL + i)) sel_q[i] <= gp_sel_t'(bus_wdata[3:0]);
    end
  end

  // Read path
  always_comb begin
    rd_mux = '0;
    if (bus_addr == A_GLOBAL) rd_mux = gmask_q;
    if (bus_addr == A_STATUS) rd_mux = status;
    if (bus_addr == A_FIXCTL) rd_mux = DATA_W'(fix_ctl_q);
    for (int i = 0; i < NUM_GP; i++) begin
      if (bus_addr == ADDR_W'(A_GPCNT + i)) rd_mux = DATA_W'(cnt[i]);
      if (bus_addr == ADDR_W'(A_GPSEL + i)) rd_mux = DATA_W'(sel_q[i]);
    end
    for (int j = 0; j < NUM_FIX; j++)
      if (bus_addr == ADDR_W'(A_FXCNT + j)) rd_mux = DATA_W'(cnt[NUM_GP+j]);
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rd_mux;
  end

  // R4: a cleared global mask freezes every counter absent writes
  a_r4_freeze: assert property (@(posedge clk) disable iff (rst)
    ((gmask_q == '0) && !bus_wr) |=> $stable(cnt));
  // R9: only implemented mask positions can be set
  a_r9_mask_impl: assert property (@(posedge clk) disable iff (rst)
    bus_wr |=> ((gmask_q & ~IMPL) == '0));

  generate
    for (genvar f = 0; f < NUM_FIX; f++) begin : g_fix_chk
      // R3: a zero field stops the fixed counter
      a_r3_field_off: assert property (@(posedge clk) disable iff (rst)
        ((fix_ctl_q[4*f+:4] == 4'h0) && !cwr[NUM_GP+f]) |=> $stable(cnt[NUM_GP+f]));
    end
  endgenerate
endmodule

// File: tb/evt_counter_bank_bench.sv
module evt_counter_bank_bench;
  localparam int G = 4;
  localparam int F = 3;
  localparam int W = 48;
  localparam logic [63:0] CMASK = (64'd1 << W) - 1;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        priv_mode = 1'b1;
  logic [G+F-1:0] evt_in = '0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [63:0] bus_wdata = '0;
  logic [63:0] bus_rdata;
  logic        irq_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #4 clk = ~clk;

  evt_counter_bank #(.NUM_GP(G), .NUM_FIX(F), .CNT_W(W)) u_evt_counter_bank (
    .clk(clk), .rst(rst), .priv_mode(priv_mode), .evt_in(evt_in),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_o(irq_o)
  );

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [63:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [63:0] d);
    bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic pulse(int idx, int n);
    evt_in = '0;
    evt_in[idx] = 1'b1;
    repeat (n) @(negedge clk);
    evt_in = '0;
  endtask

  task automatic t_reset;
    logic [63:0] v;
    rd(8'h10, v); chk("R1 gp counter", v, 0);
    rd(8'h30, v); chk("R1 fixed counter", v, 0);
    rd(8'h20, v); chk("R1 select", v, 0);
    rd(8'h03, v); chk("R1 fixed ctl", v, 0);
    rd(8'h00, v); chk("R1 global mask", v, 0);
    rd(8'h01, v); chk("R1 status", v, 0);
    chk("R1 irq", 64'(irq_o), 0);
  endtask

  task automatic t_gp_count;
    logic [63:0] v;
    wr(8'h00, 64'h1);
    wr(8'h20, 64'h5);          // priv + enable
    priv_mode = 1'b1; pulse(0, 3);
    rd(8'h10, v); chk("R2 priv count", v, 3);
    priv_mode = 1'b0; pulse(0, 4);
    rd(8'h10, v); chk("R2 user mode blocked", v, 3);
    wr(8'h20, 64'h3);          // modes but no local enable
    priv_mode = 1'b1; pulse(0, 2);
    rd(8'h10, v); chk("R2 local enable off", v, 3);
    wr(8'h20, 64'h5);
    pulse(1, 2);               // other counter's event
    rd(8'h10, v); chk("R2 other event ignored", v, 3);
  endtask

  task automatic t_fixed;
    logic [63:0] v;
    wr(8'h00, 64'h7_0000_0000);
    wr(8'h03, 64'h0021);       // fix0 priv, fix1 user
    priv_mode = 1'b0; pulse(G, 3);
    rd(8'h30, v); chk("R3 fixed0 user blocked", v, 0);
    priv_mode = 1'b1; pulse(G, 3);
    rd(8'h30, v); chk("R3 fixed0 priv count", v, 3);
    priv_mode = 1'b0; pulse(G+1, 2);
    rd(8'h31, v); chk("R3 fixed1 user count", v, 2);
    wr(8'h03, 64'h0020);
    priv_mode = 1'b1; pulse(G, 4);
    rd(8'h30, v); chk("R3 zero field stops", v, 3);
  endtask

  task automatic t_freeze;
    logic [63:0] v;
    wr(8'h23, 64'h5);
    wr(8'h00, 64'h8);
    priv_mode = 1'b1; pulse(3, 2);
    rd(8'h13, v); chk("R4 pre-freeze", v, 2);
    wr(8'h00, 64'h0);
    pulse(3, 5);
    rd(8'h13, v); chk("R4 frozen", v, 2);
  endtask

  task automatic t_overflow;
    logic [63:0] v;
    wr(8'h02, 64'hFFFF_FFFF_FFFF_FFFF);
    wr(8'h21, 64'h7);          // gp1 no irq
    wr(8'h22, 64'hF);          // gp2 irq
    wr(8'h00, 64'h6);
    priv_mode = 1'b1;
    wr(8'h11, (64'd1 - 64'd5) & CMASK);
    pulse(1, 5);
    rd(8'h11, v); chk("R5 preset 1-N ends at 1", v, 1);
    rd(8'h01, v); chk("R5 status bit1", v, 64'h2);
    chk("R7 no irq without enable", 64'(irq_o), 0);
    wr(8'h12, CMASK - 1);
    pulse(2, 3);
    rd(8'h12, v); chk("R5 wrap modulo width", v, 1);
    rd(8'h01, v); chk("R5 status bits 1,2", v, 64'h6);
    chk("R7 irq raised", 64'(irq_o), 1);
    wr(8'h02, 64'h2);
    rd(8'h01, v); chk("R6 clears only bit1", v, 64'h4);
    chk("R7 irq held", 64'(irq_o), 1);
    wr(8'h02, 64'h4);
    @(negedge clk);
    chk("R7 irq falls", 64'(irq_o), 0);
    rd(8'h01, v); chk("R6 all clear", v, 0);
  endtask

  task automatic t_fixed_wrap;
    logic [63:0] v;
    wr(8'h00, 64'h4_0000_0000);
    wr(8'h03, 64'h0B00);       // fix2 priv+user+irq
    wr(8'h32, CMASK);
    priv_mode = 1'b1; pulse(G+2, 1);
    rd(8'h32, v); chk("R5 fixed wraps to 0", v, 0);
    rd(8'h01, v); chk("R5 fixed status bit 34", v, 64'h4_0000_0000);
    chk("R7 fixed irq", 64'(irq_o), 1);
    // collision: clear during wrap keeps bit
    wr(8'h32, CMASK);
    evt_in[G+2] = 1'b1;
    wr(8'h02, 64'h4_0000_0000);
    evt_in = '0;
    rd(8'h01, v); chk("R6 wrap beats clear", v, 64'h4_0000_0000);
    wr(8'h02, 64'h4_0000_0000);
    wr(8'h03, 64'h0);
  endtask

  task automatic t_running_write;
    logic [63:0] v;
    wr(8'h20, 64'h5);
    wr(8'h00, 64'h1);
    wr(8'h10, 64'h0);
    priv_mode = 1'b1;
    evt_in = '0; evt_in[0] = 1'b1;
    repeat (3) @(negedge clk);
    wr(8'h10, 64'd100);
    repeat (4) @(negedge clk);
    evt_in = '0;
    rd(8'h10, v); chk("R8 continues from written value", v, 104);
  endtask

  task automatic t_regs;
    logic [63:0] v;
    wr(8'h00, 64'hFFFF_FFFF_FFFF_FFFF);
    rd(8'h00, v); chk("R9 mask implemented bits", v, 64'h7_0000_000F);
    rd(8'h7F, v); chk("R9 unmapped reads zero", v, 0);
    wr(8'h31, 64'hFFFF_FFFF_FFFF_FFFF);
    rd(8'h31, v); chk("R9 counter zero-extended", v, CMASK);
    wr(8'h00, 64'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_gp_count();
    t_fixed();
    t_freeze();
    t_overflow();
    t_fixed_wrap();
    t_running_write();
    t_regs();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule